// File: doc/BRIEF.md
# Prioritized Interrupt Controller Unit

This block collects sixteen external interrupt requests, resolves them by programmable priority, and raises one interrupt line towards a processor. Every source carries its own trigger setting (low or high level, falling or rising edge) and an 8-bit priority level. A level of zero switches the source off. A threshold register hides every source whose level does not exceed it. The number and level of the source that currently wins can be read from a status word.

Software reaches the block through a plain 32-bit register bus. The bus has a word address, a write strobe, write data and combinational read data, and writes take effect on the clock edge. The request pins are asynchronous and pass through a two-flop synchroniser before use. An edge-mode source keeps its captured edge until software writes that source's number, together with a qualifier bit, to the edge-clear word. This normally happens after the interrupt has been serviced.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Bit 0 of the control word (address 0) is the global enable. While it is 0, `irq_o` stays low and the status word reports no interrupt.
- R2: The trigger mode is a 2-bit code: 00 active low, 01 active high, 10 falling edge, 11 rising edge. Address 2 holds sources 0-7 and address 3 holds sources 8-15, with source n at bits (n mod 8)*2+1:(n mod 8)*2.
- R3: The 8-bit level of source n is at address 8 + n/2, bits (n&1)*8+7:(n&1)*8. A level of 0 disables the source.
- R4: The threshold word (address 16, bits 7:0) admits only sources whose level is strictly greater than it.
- R5: Among the admitted active sources, the highest level wins. On equal levels, the lowest source number wins.
- R6: In an edge mode, a synchronised transition in the selected direction sets the source's edge latch. The latch stays set after the input returns, until it is cleared.
- R7: A write to address 20 with bit 8 set clears the edge latch of the source given in bits 3:0. A write with bit 8 clear has no effect. Address 20 reads as 0.
- R8: The status word (address 24) has bit 16 = 1 when nothing is pending and 0 otherwise, bits 10:8 = the low three bits of the winner's level, and bits 4:0 = the winner's number. The fields read 0 when nothing is pending. Reading it changes no state.
- R9: `irq_o` is high exactly when the global enable is set and at least one admitted active source exists.
- R10: A level request reaches `irq_o` two rising clock edges after the input changes, and not after one.
- R11: Unused addresses read as 0, and writes to them change no register.
- R12: After reset every register is 0: enable off, all modes active-low, all levels 0, threshold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | Asynchronous interrupt request pins |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its defaults: 16 sources, 8-bit levels and a 6-bit address. With these, the 4-bit clear field covers every source and the level words fill addresses 8 to 15. Random levels are kept in 0..7 and thresholds in 0..3. This makes ties between sources, levels equal to the threshold and disabled sources common, so the tie rule and the strict comparison are exercised often. Directed cases cover edge latches that outlive their input, unqualified clears and the two-edge synchroniser delay.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  localparam int unsigned A_CTRL      = 0;
  localparam int unsigned A_MODE_BASE = 2;
  localparam int unsigned A_LVL_BASE  = 8;
  localparam int unsigned A_THRESH    = 16;
  localparam int unsigned A_ECLR      = 20;
  localparam int unsigned A_STAT      = 24;

  localparam int unsigned ECLR_QUAL_BIT = 8;
  localparam int unsigned STAT_NONE_BIT = 16;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;

  // mode words: eight 2-bit fields per word
  function automatic int unsigned mode_word(input int unsigned n);
    return n / 8;
  endfunction

  function automatic int unsigned mode_ofs(input int unsigned n);
    return (n % 8) * 2;
  endfunction

  // level words: two byte fields in the low half, upper half for n >= 16
  function automatic int unsigned lvl_word(input int unsigned n);
    return (n % 16) / 2;
  endfunction

  function automatic int unsigned lvl_ofs(input int unsigned n);
    return (n / 16) * 16 + (n & 1) * 8;
  endfunction

  function automatic logic is_edge(input logic [1:0] m);
    return m[1];
  endfunction

  // level-sensitive match of a synchronised input against the mode
  function automatic logic level_hit(input logic [1:0] m, input logic s);
    return m[0] ? s : ~s;
  endfunction

  // qualified edge for the selected direction
  function automatic logic edge_hit(input logic [1:0] m, input logic cur, input logic prev);
    return m[1] & (m[0] ? (cur & ~prev) : (~cur & prev));
  endfunction

endpackage

// File: rtl/irq_input_stage.sv
module irq_input_stage
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned IDX_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC-1:0][1:0]  mode_i,
  input  logic                     clr_vld_i,
  input  logic [IDX_W-1:0]         clr_idx_i,
  output logic [NUM_SRC-1:0]       active_o,
  output logic [NUM_SRC-1:0]       edge_ev_o,
  output logic [NUM_SRC-1:0]       latch_o
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic sync1_q, sync2_q, prev_q, latch_q;
    logic clr_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync1_q <= 1'b0;
        sync2_q <= 1'b0;
        prev_q  <= 1'b0;
      end else begin
        sync1_q <= req_i[g];
        sync2_q <= sync1_q;
        prev_q  <= sync2_q;
      end
    end

    assign edge_ev_o[g] = edge_hit(mode_i[g], sync2_q, prev_q);
    assign clr_hit      = clr_vld_i && (clr_idx_i == IDX_W'(g));

    // a new edge wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            latch_q <= 1'b0;
      else if (edge_ev_o[g]) latch_q <= 1'b1;
      else if (clr_hit)      latch_q <= 1'b0;
    end

    assign latch_o[g]  = latch_q;
    assign active_o[g] = is_edge(mode_i[g]) ? latch_q : level_hit(mode_i[g], sync2_q);
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned LVL_W   = 8,
  parameter int unsigned IDX_W   = 4
) (
  input  logic [NUM_SRC-1:0]             active_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0]  lvl_i,
  input  logic [LVL_W-1:0]               thresh_i,
  output logic                           found_o,
  output logic [IDX_W-1:0]               win_idx_o,
  output logic [LVL_W-1:0]               win_lvl_o
);

  // best starts at the threshold, so only strictly higher levels qualify;
  // strict comparison keeps the lowest index on ties
  always_comb begin
    logic [LVL_W-1:0] best;
    best      = thresh_i;
    found_o   = 1'b0;
    win_idx_o = '0;
    win_lvl_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (active_i[i] && (lvl_i[i] > best)) begin
        best      = lvl_i[i];
        found_o   = 1'b1;
        win_idx_o = IDX_W'(i);
        win_lvl_o = lvl_i[i];
      end
    end
  end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned LVL_W   = 8,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [31:0]                    wdata_i,
  output logic [31:0]                    rdata_o,
  input  logic                           pend_i,
  input  logic [IDX_W-1:0]               win_idx_i,
  input  logic [LVL_W-1:0]               win_lvl_i,
  output logic                           gen_en_o,
  output logic [NUM_SRC-1:0][1:0]        mode_o,
  output logic [NUM_SRC-1:0][LVL_W-1:0]  lvl_o,
  output logic [LVL_W-1:0]               thresh_o,
  output logic                           clr_vld_o,
  output logic [IDX_W-1:0]               clr_idx_o
);

  localparam int unsigned VEC_W = 5;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned target);
    return a == ADDR_W'(target);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en_o <= 1'b0;
      mode_o   <= '0;
      lvl_o    <= '0;
      thresh_o <= '0;
    end else if (wr_en_i) begin
      if (hit(addr_i, A_CTRL))   gen_en_o <= wdata_i[0];
      if (hit(addr_i, A_THRESH)) thresh_o <= wdata_i[LVL_W-1:0];
      for (int i = 0; i < NUM_SRC; i++) begin
        if (hit(addr_i, A_MODE_BASE + mode_word(i)))
          mode_o[i] <= wdata_i[mode_ofs(i) +: 2];
        if (hit(addr_i, A_LVL_BASE + lvl_word(i)))
          lvl_o[i] <= wdata_i[lvl_ofs(i) +: LVL_W];
      end
    end
  end

  assign clr_vld_o = wr_en_i && hit(addr_i, A_ECLR) && wdata_i[ECLR_QUAL_BIT];
  assign clr_idx_o = wdata_i[IDX_W-1:0];

  always_comb begin
    rdata_o = '0;
    if (hit(addr_i, A_CTRL))   rdata_o[0] = gen_en_o;
    if (hit(addr_i, A_THRESH)) rdata_o[LVL_W-1:0] = thresh_o;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (hit(addr_i, A_MODE_BASE + mode_word(i)))
        rdata_o[mode_ofs(i) +: 2] = mode_o[i];
      if (hit(addr_i, A_LVL_BASE + lvl_word(i)))
        rdata_o[lvl_ofs(i) +: LVL_W] = lvl_o[i];
    end
    if (hit(addr_i, A_STAT)) begin
      rdata_o[STAT_NONE_BIT] = ~pend_i;
      if (pend_i) begin
        rdata_o[10:8]      = win_lvl_i[2:0];
        rdata_o[VEC_W-1:0] = VEC_W'(win_idx_i);
      end
    end
  end

  logic unused_lvl_hi;
  assign unused_lvl_hi = ^win_lvl_i[LVL_W-1:3];

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned LVL_W   = 8,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o
);

  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic                          gen_en;
  logic [NUM_SRC-1:0][1:0]       mode;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
  logic [LVL_W-1:0]              thresh;
  logic                          clr_vld;
  logic [IDX_W-1:0]              clr_idx;
  logic [NUM_SRC-1:0]            active, edge_ev, latch;
  logic                          found;
  logic [IDX_W-1:0]              win_idx;
  logic [LVL_W-1:0]              win_lvl;

  irq_regs #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .pend_i(irq_o), .win_idx_i(win_idx), .win_lvl_i(win_lvl),
    .gen_en_o(gen_en), .mode_o(mode), .lvl_o(lvl), .thresh_o(thresh),
    .clr_vld_o(clr_vld), .clr_idx_o(clr_idx)
  );

  irq_input_stage #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_in (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mode_i(mode),
    .clr_vld_i(clr_vld), .clr_idx_i(clr_idx),
    .active_o(active), .edge_ev_o(edge_ev), .latch_o(latch)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_arb (
    .active_i(active), .lvl_i(lvl), .thresh_i(thresh),
    .found_o(found), .win_idx_o(win_idx), .win_lvl_o(win_lvl)
  );

  assign irq_o = gen_en & found;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned LVL_W   = 8,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned ADDR_W  = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               gen_en,
  input logic               irq_o,
  input logic               found,
  input logic [LVL_W-1:0]   win_lvl,
  input logic [LVL_W-1:0]   thresh,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [31:0]        rdata_o,
  input logic               clr_vld,
  input logic [IDX_W-1:0]   clr_idx,
  input logic [NUM_SRC-1:0] edge_ev,
  input logic [NUM_SRC-1:0] latch
);

  assert_gate_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> !irq_o);

  assert_win_above_thresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (win_lvl > thresh));

  assert_stat_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_W'(24)) |-> (rdata_o[16] == !irq_o));

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (latch[k] && !(clr_vld && clr_idx == IDX_W'(k))) |=> latch[k]);

    assert_latch_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      edge_ev[k] |=> latch[k]);

    assert_latch_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vld && clr_idx == IDX_W'(k) && !edge_ev[k]) |=> !latch[k]);
  end

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .irq_o(irq_o), .found(found),
  .win_lvl(win_lvl), .thresh(thresh), .addr_i(addr_i), .rdata_o(rdata_o),
  .clr_vld(clr_vld), .clr_idx(clr_idx), .edge_ev(edge_ev), .latch(latch)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;

  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  logic [1:0] m_mode [NS];
  logic [7:0] m_lvl  [NS];
  logic       m_lat  [NS];
  logic [7:0] m_thr;
  logic       m_en;

  always #5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = 6'(a);
    #1 d = rdata;
  endtask

  task automatic set_mode(input int n, input logic [1:0] m);
    logic [31:0] w;
    m_mode[n] = m;
    w = '0;
    for (int j = 0; j < 8; j++) w[j*2 +: 2] = m_mode[(n/8)*8 + j];
    wr(2 + n/8, w);
  endtask

  task automatic set_lvl(input int n, input logic [7:0] l);
    m_lvl[n] = l;
    wr(8 + n/2, {16'h0, m_lvl[(n/2)*2+1], m_lvl[(n/2)*2]});
  endtask

  task automatic set_thr(input logic [7:0] t);
    m_thr = t; wr(16, {24'h0, t});
  endtask

  task automatic set_en(input logic e);
    m_en = e; wr(0, {31'h0, e});
  endtask

  task automatic clear_edge(input int n);
    m_lat[n] = 1'b0; wr(20, 32'h100 | 32'(n));
  endtask

  // change pins, update the edge model, wait past the synchroniser
  task automatic drive_in(input logic [15:0] nv);
    @(negedge clk);
    for (int n = 0; n < NS; n++) begin
      if (m_mode[n][1] && nv[n] != req[n] && nv[n] == m_mode[n][0]) m_lat[n] = 1'b1;
    end
    req = nv;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_stat(output logic pend);
    int best_n; logic [7:0] best;
    logic act;
    best = m_thr; best_n = -1;
    for (int n = 0; n < NS; n++) begin
      act = m_mode[n][1] ? m_lat[n] : (m_mode[n][0] ? req[n] : ~req[n]);
      if (act && m_lvl[n] > best) begin best = m_lvl[n]; best_n = n; end
    end
    pend = m_en && (best_n >= 0);
    if (!pend) return 32'h0001_0000;
    return {21'h0, best[2:0], 3'h0, 5'(best_n)};
  endfunction

  task automatic chk_stat(input string tag);
    logic [31:0] s, e; logic p;
    e = exp_stat(p);
    rd(24, s);
    chk({tag, " status"}, s, e);
    chk({tag, " irq"}, {31'h0, irq}, {31'h0, p});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    void'($urandom(32'd7331));
    for (int n = 0; n < NS; n++) begin m_mode[n] = 2'b00; m_lvl[n] = 8'h0; m_lat[n] = 1'b0; end
    m_thr = 8'h0; m_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset values
    rd(0, v);  chk("R12 ctrl", v, 32'h0);
    rd(2, v);  chk("R12 mode0", v, 32'h0);
    rd(3, v);  chk("R12 mode1", v, 32'h0);
    rd(15, v); chk("R12 lvl7", v, 32'h0);
    rd(16, v); chk("R12 thresh", v, 32'h0);
    chk_stat("R12 R8 reset");

    // R3 level 0 disables even an active low-mode input
    set_en(1'b1);
    chk_stat("R3 all levels zero");
    set_lvl(3, 8'd5);
    rd(9, v); chk("R3 level layout", v, 32'h0000_0500);
    chk_stat("R2 low-level active");
    chk("R8 value", {31'h0, irq}, 32'h1);

    // R4 strict threshold
    set_thr(8'd5); chk_stat("R4 equal threshold blocked");
    set_thr(8'd4); chk_stat("R4 below threshold passes");
    set_thr(8'd0);

    // R5 ties and priority
    set_lvl(7, 8'd5);  chk_stat("R5 tie lowest index");
    set_lvl(12, 8'd9); chk_stat("R5 highest level");
    rd(24, v); chk("R5 R8 winner field", v, 32'h0000_010C);

    // R1 global enable
    set_en(1'b0); chk_stat("R1 disabled");
    chk("R1 irq low", {31'h0, irq}, 32'h0);
    set_en(1'b1);

    // R2 mode layout readback
    set_mode(9, 2'b10);
    rd(3, v); chk("R2 mode layout", v, 32'h0000_0008);
    set_mode(9, 2'b00);
    for (int n = 0; n < NS; n++) if (m_lvl[n] != 0) set_lvl(n, 8'd0);

    // R10 two-edge latency, active-high source 1
    set_mode(1, 2'b01); set_lvl(1, 8'd6);
    @(negedge clk); req[1] = 1'b1;
    @(posedge clk); #1 chk("R10 after one edge", {31'h0, irq}, 32'h0);
    @(posedge clk); #1 chk("R10 after two edges", {31'h0, irq}, 32'h1);
    drive_in(req & ~16'h0002);
    chk_stat("R2 high-level released");

    // R6 R7 rising edge on source 5
    set_mode(5, 2'b11); set_lvl(5, 8'd7);
    drive_in(req | 16'h0020);
    chk_stat("R6 rising latched");
    drive_in(req & ~16'h0020);
    chk_stat("R6 held after return");
    rd(24, v); rd(24, v2); chk("R8 read no side effect", v2, v);
    wr(20, 32'h0000_0005);
    chk_stat("R7 unqualified clear ignored");
    chk("R7 still pending", {31'h0, irq}, 32'h1);
    clear_edge(5);
    chk_stat("R7 qualified clear");
    rd(20, v); chk("R7 read zero", v, 32'h0);

    // R6 falling edge on source 9
    set_mode(9, 2'b10); set_lvl(9, 8'd2);
    drive_in(req | 16'h0200);
    chk_stat("R6 rise ignored in falling mode");
    drive_in(req & ~16'h0200);
    chk_stat("R6 falling latched");
    clear_edge(9);

    // R11 unused address
    wr(5, 32'hFFFF_FFFF);
    rd(5, v); chk("R11 unused reads zero", v, 32'h0);
    rd(0, v); chk("R11 ctrl untouched", v, 32'h1);
    rd(16, v); chk("R11 thresh untouched", v, 32'h0);
    chk_stat("R11 state untouched");

    // random mix, R9 R5 R4 R6 R7
    for (int it = 0; it < 300; it++) begin
      int k;
      k = $urandom % 10;
      if (k < 3) set_mode($urandom % NS, 2'($urandom));
      else if (k < 6) set_lvl($urandom % NS, 8'($urandom % 8));
      else if (k == 6) set_thr(8'($urandom % 4));
      else if (k == 7) set_en(($urandom % 5) != 0);
      drive_in(req ^ 16'($urandom & $urandom));
      if (($urandom % 3) == 0) clear_edge($urandom % NS);
      chk_stat("R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule